// File: doc/BRIEF.md
# Full-Duplex Serial Transceiver with RTS/CTS Handshake

The block moves bytes in both directions over a two-wire asynchronous serial link, with two more wires for the handshake. Bytes offered on a valid/ready push port go into a small transmit queue. They are shifted out on the transmit pin as 8N1 frames: one low start bit, eight data bits sent least significant bit first, and one high stop bit. Frames arriving on the receive pin are oversampled at 16 times the bit rate, reassembled, and placed with an error flag in a 16-entry receive queue. A valid/ready pop port drains that queue. The two directions run independently and at the same time, and neither end acts as a controller.

The handshake pins are active low and are wired crosswise to the peer. The local request-to-send output is driven from the receive queue occupancy. It is withdrawn once the occupancy reaches a programmable watermark, so that bytes the peer already has in flight still find room. It is offered again only after the queue has drained four entries below the watermark. The clear-to-send input is synchronised and consulted only when the transmitter is about to load a new byte. A byte already being shifted out always finishes.

Top module: `uart_hs`

## Requirements
- R1: Each transmitted frame is one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts 16 × `baud_div_i` clock cycles, and `tx_o` idles high.
- R2: A new byte is loaded for transmission only while `cts_ni` (active low) has been low for the two-flop synchroniser. While `cts_ni` is high, `tx_o` stays high and queued bytes wait.
- R3: If `cts_ni` goes high while a byte is being shifted out, that byte completes in full and no further byte starts until `cts_ni` is low again.
- R4: The transmit queue holds 4 bytes. `tx_ready_o` is low while it is full.
- R5: The receiver confirms a start bit by sampling the line again half a bit after the falling edge. A low pulse shorter than half a bit produces no byte. Valid frames appear on `rx_data_o` in arrival order, with `rx_ferr_o` low.
- R6: A frame whose stop bit samples low is still stored, with `rx_ferr_o` high. The receiver then waits for the line to return high before it looks for the next start bit.
- R7: `rts_no` (active low) goes high when the receive queue occupancy reaches `rts_thresh_i` (default 12). The watermark can be changed at run time.
- R8: After it has been withdrawn, `rts_no` returns low only when occupancy + 4 < `rts_thresh_i`, which gives 4 entries of hysteresis.
- R9: A byte that completes while the 16-entry receive queue is full is dropped. It sets `rx_overrun_o`, which stays set until reset.
- R10: Transmit and receive run concurrently without disturbing each other.
- R11: After reset, `tx_o` is high, `rts_no` is low, `tx_ready_o` is high, `rx_valid_o` is low and `rx_overrun_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_div_i | input | 16 | Clock cycles per oversample tick (0 is treated as 1) |
| rts_thresh_i | input | 5 | Receive queue watermark for withdrawing RTS |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmit queue can accept a byte |
| rx_data_o | output | 8 | Oldest received byte |
| rx_ferr_o | output | 1 | Framing error flag of that byte |
| rx_valid_o | output | 1 | Receive queue not empty |
| rx_ready_i | input | 1 | Pop the oldest received byte |
| rx_overrun_o | output | 1 | Sticky: a received byte was dropped |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| rts_no | output | 1 | Request to send, active low |
| cts_ni | input | 1 | Clear to send, active low |

## Verification
A transmitted bit starts in the cycle after the load, and each bit lasts exactly 64 cycles at the bench divisor of 4. The bench monitor therefore finds the falling start edge, steps 32 cycles to mid-bit, and samples every 64 cycles on falling clock edges. A received byte enters the queue about two synchroniser cycles plus half a bit after the start of its stop bit, and `rts_no` follows the occupancy two cycles later. The bench checks the handshake and queue state only after the whole stop bit has been driven, which is well past both latencies. Checks that look for the absence of traffic wait at least two full frame times before they sample.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;
  localparam int OVS      = 16;  // oversample ticks per bit
  localparam int OVS_MID  = 7;   // tick index of mid start bit
  localparam int DATA_W   = 8;
  localparam int DIV_W    = 16;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT
  } rx_state_e;
endpackage

// File: rtl/uart_hs_fifo.sv
module uart_hs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign do_push = push_i && (count_o != CW'(DEPTH));
  assign do_pop  = pop_i && (count_o != '0);
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr    <= '0;
      rptr    <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (do_push && !do_pop)      count_o <= count_o + 1'b1;
      else if (do_pop && !do_push) count_o <= count_o - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= wdata_i;
  end
endmodule

// File: rtl/uart_hs_tx.sv
module uart_hs_tx
  import uart_hs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              avail_i,
  input  logic              cts_ok_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int FRAME = DATA_W + 2;

  logic [DIV_W-1:0]         div_cnt, div_last;
  logic [$clog2(OVS)-1:0]   os_cnt;
  logic [$clog2(FRAME)-1:0] bit_cnt;
  logic [FRAME-1:0]         sh;

  assign div_last = (baud_div_i == '0) ? '0 : baud_div_i - 1'b1;
  // CTS is consulted only here, at the load decision
  assign pop_o    = !busy_o && avail_i && cts_ok_i;
  assign tx_o     = busy_o ? sh[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      div_cnt <= '0;
      os_cnt  <= '0;
      bit_cnt <= '0;
      sh      <= '1;
    end else if (!busy_o) begin
      if (pop_o) begin
        busy_o  <= 1'b1;
        sh      <= {1'b1, data_i, 1'b0};
        div_cnt <= '0;
        os_cnt  <= '0;
        bit_cnt <= '0;
      end
    end else if (div_cnt != div_last) begin
      div_cnt <= div_cnt + 1'b1;
    end else begin
      div_cnt <= '0;
      if (os_cnt != $bits(os_cnt)'(OVS - 1)) begin
        os_cnt <= os_cnt + 1'b1;
      end else begin
        os_cnt <= '0;
        sh     <= {1'b1, sh[FRAME-1:1]};
        if (bit_cnt == $bits(bit_cnt)'(FRAME - 1)) busy_o <= 1'b0;
        else                                       bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_hs_rx.sv
module uart_hs_rx
  import uart_hs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              rx_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o
);
  rx_state_e                 state;
  logic [1:0]                rx_q;
  logic                      rx_s, tick;
  logic [DIV_W-1:0]          div_cnt, div_last;
  logic [$clog2(OVS)-1:0]    os_cnt;
  logic [$clog2(DATA_W)-1:0] bit_cnt;

  assign rx_s     = rx_q[1];
  assign div_last = (baud_div_i == '0) ? '0 : baud_div_i - 1'b1;
  assign tick     = (div_cnt == div_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= 2'b11;
      state   <= RX_IDLE;
      div_cnt <= '0;
      os_cnt  <= '0;
      bit_cnt <= '0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
      push_o  <= 1'b0;
    end else begin
      rx_q   <= {rx_q[0], rx_i};
      push_o <= 1'b0;
      if (state != RX_IDLE && state != RX_WAIT)
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
      unique case (state)
        RX_IDLE: if (!rx_s) begin
          state   <= RX_START;
          div_cnt <= '0;
          os_cnt  <= '0;
        end
        RX_START: if (tick) begin
          if (os_cnt == $bits(os_cnt)'(OVS_MID)) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            state   <= rx_s ? RX_IDLE : RX_DATA;  // glitch rejected
          end else os_cnt <= os_cnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (os_cnt == $bits(os_cnt)'(OVS - 1)) begin
            os_cnt <= '0;
            data_o <= {rx_s, data_o[DATA_W-1:1]};
            if (bit_cnt == $bits(bit_cnt)'(DATA_W - 1)) state <= RX_STOP;
            else                                       bit_cnt <= bit_cnt + 1'b1;
          end else os_cnt <= os_cnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (os_cnt == $bits(os_cnt)'(OVS - 1)) begin
            os_cnt <= '0;
            push_o <= 1'b1;
            ferr_o <= !rx_s;
            state  <= rx_s ? RX_IDLE : RX_WAIT;
          end else os_cnt <= os_cnt + 1'b1;
        end
        RX_WAIT: if (rx_s) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_hs.sv
module uart_hs
  import uart_hs_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 16,
  parameter int HYST     = 4,
  localparam int CW      = $clog2(RX_DEPTH + 1),
  localparam int TCW     = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic [CW-1:0]     rts_thresh_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ferr_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              rx_overrun_o,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              rts_no,
  input  logic              cts_ni
);
  logic [1:0]        cts_q;
  logic              cts_ok;
  logic [TCW-1:0]    tx_cnt;
  logic [DATA_W-1:0] tx_head;
  logic              tx_pop, tx_busy;
  logic              rx_push, rx_ferr_new, rx_rdy;
  logic [DATA_W-1:0] rx_byte;
  logic [CW-1:0]     rx_count;
  logic              rx_full;

  assign tx_ready_o = (tx_cnt != TCW'(TX_DEPTH));
  assign rx_valid_o = (rx_count != '0);
  assign rx_full    = (rx_count == CW'(RX_DEPTH));
  assign cts_ok     = cts_q[1];
  assign rts_no     = ~rx_rdy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cts_q        <= 2'b00;
      rx_rdy       <= 1'b1;
      rx_overrun_o <= 1'b0;
    end else begin
      cts_q <= {cts_q[0], ~cts_ni};
      if (rx_count >= rts_thresh_i) rx_rdy <= 1'b0;
      else if ((CW+1)'(rx_count) + (CW+1)'(HYST) < (CW+1)'(rts_thresh_i)) rx_rdy <= 1'b1;
      if (rx_push && rx_full) rx_overrun_o <= 1'b1;
    end
  end

  uart_hs_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) tx_fifo_i (
    .clk_i, .rst_ni,
    .push_i (tx_valid_i),
    .wdata_i(tx_data_i),
    .pop_i  (tx_pop),
    .rdata_o(tx_head),
    .count_o(tx_cnt)
  );

  uart_hs_tx tx_i (
    .clk_i, .rst_ni, .baud_div_i,
    .data_i  (tx_head),
    .avail_i (tx_cnt != '0),
    .cts_ok_i(cts_ok),
    .pop_o   (tx_pop),
    .busy_o  (tx_busy),
    .tx_o
  );

  uart_hs_rx rx_i_u (
    .clk_i, .rst_ni, .baud_div_i,
    .rx_i,
    .push_o(rx_push),
    .data_o(rx_byte),
    .ferr_o(rx_ferr_new)
  );

  uart_hs_fifo #(.W(DATA_W + 1), .DEPTH(RX_DEPTH)) rx_fifo_i (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .wdata_i({rx_ferr_new, rx_byte}),
    .pop_i  (rx_ready_i),
    .rdata_o({rx_ferr_o, rx_data_o}),
    .count_o(rx_count)
  );
endmodule

// File: rtl/uart_hs_chk.sv
module uart_hs_chk #(
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_o,
  input logic          tx_busy,
  input logic          cts_ok,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] rts_thresh_i,
  input logic          rts_no,
  input logic          rx_overrun_o
);
  // R2
  cts_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> $past(cts_ok));

  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> tx_o);

  // R7
  rts_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count >= rts_thresh_i) |=> rts_no);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overrun_o |=> rx_overrun_o);

  // R9
  rx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count <= CW'(DEPTH));
endmodule

bind uart_hs uart_hs_chk #(.CW(CW), .DEPTH(RX_DEPTH)) chk_i (
  .clk_i, .rst_ni, .tx_o, .tx_busy, .cts_ok, .rx_count,
  .rts_thresh_i, .rts_no, .rx_overrun_o
);

// File: tb/uart_hs_tb_top.sv
module uart_hs_tb_top;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic       clk_i = 0, rst_ni = 0;
  logic [15:0] baud_div_i = 16'(DIV);
  logic [4:0] rts_thresh_i = 5'd12;
  logic [7:0] tx_data_i = 0;
  logic       tx_valid_i = 0, rx_ready_i = 0, rx_i = 1, cts_ni = 0;
  logic       tx_ready_o, rx_ferr_o, rx_valid_o, rx_overrun_o, tx_o, rts_no;
  logic [7:0] rx_data_o;

  int errors = 0, checks = 0;
  logic [7:0] tx_got [0:63];
  int tx_n = 0, tx_stop_bad = 0;
  logic [7:0] exp_q [0:63];
  logic [7:0] rd;
  logic rf;

  always #10 clk_i = ~clk_i;

  uart_hs dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected RTS level (1 = withdrawn) after a change of occupancy
  function automatic bit exp_rts(input int cnt, input int thr, input bit prev);
    if (cnt >= thr) return 1'b1;
    if (cnt + 4 < thr) return 1'b0;
    return prev;
  endfunction

  // TX line monitor, samples mid-bit on falling clock edges
  initial forever begin
    logic [7:0] b;
    @(negedge tx_o);
    repeat (BIT/2) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk_i);
      b[i] = tx_o;
    end
    repeat (BIT) @(negedge clk_i);
    if (tx_o !== 1'b1) tx_stop_bad++;
    tx_got[tx_n] = b;
    tx_n++;
  end

  task automatic send_rx(input logic [7:0] b, input bit stop_ok);
    @(negedge clk_i);
    rx_i = 0;
    repeat (BIT) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (BIT) @(negedge clk_i);
    end
    rx_i = stop_ok;
    repeat (BIT) @(negedge clk_i);
    rx_i = 1;
    repeat (BIT) @(negedge clk_i);
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk_i);
    while (!tx_ready_o) @(negedge clk_i);
    tx_data_i = b;
    tx_valid_i = 1;
    @(negedge clk_i);
    tx_valid_i = 0;
  endtask

  task automatic pop_rx(output logic [7:0] d, output logic f);
    @(negedge clk_i);
    while (!rx_valid_o) @(negedge clk_i);
    d = rx_data_o;
    f = rx_ferr_o;
    rx_ready_i = 1;
    @(negedge clk_i);
    rx_ready_i = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base;
    bit rts_exp;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R11 reset state
    chk(tx_o === 1 && rts_no === 0 && tx_ready_o === 1 && rx_valid_o === 0 && rx_overrun_o === 0,
        "R11", {tx_o, rts_no, tx_ready_o, rx_valid_o, rx_overrun_o}, 5'b10100);

    // R1 random frames with CTS granted
    for (int i = 0; i < 6; i++) exp_q[i] = 8'($urandom);
    exp_q[0] = 8'h00; exp_q[1] = 8'hFF;
    for (int i = 0; i < 6; i++) push_tx(exp_q[i]);
    repeat (6 * 11 * BIT + 200) @(negedge clk_i);
    chk(tx_n == 6, "R1", tx_n, 6);
    for (int i = 0; i < 6; i++) chk(tx_got[i] == exp_q[i], "R1", tx_got[i], exp_q[i]);
    chk(tx_stop_bad == 0, "R1", tx_stop_bad, 0);

    // R2 / R4 CTS withheld, queue fills
    cts_ni = 1;
    repeat (10) @(negedge clk_i);
    base = tx_n;
    for (int i = 0; i < 4; i++) begin exp_q[i] = 8'($urandom); push_tx(exp_q[i]); end
    chk(tx_ready_o == 0, "R4", tx_ready_o, 0);
    repeat (2 * 11 * BIT) @(negedge clk_i);
    chk(tx_n == base && tx_o == 1, "R2", tx_n, base);
    cts_ni = 0;
    repeat (4 * 11 * BIT + 200) @(negedge clk_i);
    chk(tx_n == base + 4, "R2", tx_n, base + 4);
    for (int i = 0; i < 4; i++) chk(tx_got[base+i] == exp_q[i], "R2", tx_got[base+i], exp_q[i]);

    // R3 CTS drops mid-byte
    base = tx_n;
    push_tx(8'hA7);
    push_tx(8'h5E);
    repeat (100) @(negedge clk_i);
    cts_ni = 1;
    repeat (3 * 11 * BIT) @(negedge clk_i);
    chk(tx_n == base + 1, "R3", tx_n, base + 1);
    chk(tx_got[base] == 8'hA7, "R3", tx_got[base], 8'hA7);
    cts_ni = 0;
    repeat (11 * BIT + 200) @(negedge clk_i);
    chk(tx_n == base + 2 && tx_got[base+1] == 8'h5E, "R3", tx_got[base+1], 8'h5E);

    // R5 receive random bytes
    for (int i = 0; i < 8; i++) begin exp_q[i] = 8'($urandom); send_rx(exp_q[i], 1); end
    chk(rts_no == 0, "R7", rts_no, 0);
    for (int i = 0; i < 8; i++) begin
      pop_rx(rd, rf);
      chk(rd == exp_q[i] && rf == 0, "R5", {rf, rd}, {1'b0, exp_q[i]});
    end
    // R5 short glitch ignored
    @(negedge clk_i); rx_i = 0;
    repeat (BIT/4) @(negedge clk_i);
    rx_i = 1;
    repeat (20 * BIT) @(negedge clk_i);
    chk(rx_valid_o == 0, "R5", rx_valid_o, 0);

    // R6 framing error then clean byte
    send_rx(8'hA5, 0);
    send_rx(8'h3C, 1);
    pop_rx(rd, rf);
    chk(rd == 8'hA5 && rf == 1, "R6", {rf, rd}, 9'h1A5);
    pop_rx(rd, rf);
    chk(rd == 8'h3C && rf == 0, "R6", {rf, rd}, 9'h03C);
    @(negedge clk_i);
    chk(rx_valid_o == 0, "R6", rx_valid_o, 0);

    // R7 / R8 / R9 watermark, hysteresis, overrun
    rts_exp = 0;
    for (int i = 0; i < 17; i++) begin
      exp_q[i] = 8'($urandom);
      send_rx(exp_q[i], 1);
      if (i < 16) rts_exp = exp_rts(i + 1, 12, rts_exp);
      if (i == 10 || i == 11) chk(rts_no == rts_exp, "R7", rts_no, rts_exp);
      if (i == 15) chk(rx_overrun_o == 0, "R9", rx_overrun_o, 0);
    end
    chk(rx_overrun_o == 1, "R9", rx_overrun_o, 1);
    for (int i = 0; i < 9; i++) begin
      pop_rx(rd, rf);
      chk(rd == exp_q[i], "R9", rd, exp_q[i]);
      repeat (3) @(negedge clk_i);
      rts_exp = exp_rts(15 - i, 12, rts_exp);
      if (i == 7 || i == 8) chk(rts_no == rts_exp, "R8", rts_no, rts_exp);
    end
    for (int i = 9; i < 16; i++) begin
      pop_rx(rd, rf);
      chk(rd == exp_q[i], "R9", rd, exp_q[i]);
    end
    @(negedge clk_i);
    chk(rx_valid_o == 0 && rx_overrun_o == 1, "R9", {rx_valid_o, rx_overrun_o}, 2'b01);

    // R7 reprogrammed watermark
    rts_thresh_i = 5'd6;
    for (int i = 0; i < 6; i++) begin
      send_rx(8'(i), 1);
      if (i == 4) chk(rts_no == 0, "R7", rts_no, 0);
    end
    chk(rts_no == 1, "R7", rts_no, 1);
    for (int i = 0; i < 6; i++) pop_rx(rd, rf);
    repeat (3) @(negedge clk_i);
    chk(rts_no == 0, "R8", rts_no, 0);
    rts_thresh_i = 5'd12;

    // R10 full duplex
    base = tx_n;
    for (int i = 0; i < 3; i++) begin exp_q[i] = 8'($urandom); exp_q[8+i] = 8'($urandom); end
    fork
      for (int i = 0; i < 3; i++) push_tx(exp_q[i]);
      for (int i = 0; i < 3; i++) send_rx(exp_q[8+i], 1);
    join
    repeat (11 * BIT) @(negedge clk_i);
    chk(tx_n == base + 3, "R10", tx_n, base + 3);
    for (int i = 0; i < 3; i++) begin
      chk(tx_got[base+i] == exp_q[i], "R10", tx_got[base+i], exp_q[i]);
      pop_rx(rd, rf);
      chk(rd == exp_q[8+i] && rf == 0, "R10", rd, exp_q[8+i]);
    end

    finish_run();
  end
endmodule